// File: doc/BRIEF.md
# Encoded Microoperation Datapath

This block is the execution half of a microprogrammed accumulator machine. Each clock it takes one microinstruction, given as three 3-bit microoperation fields, and carries out the register transfers those fields select. The transfers act on a 16-bit accumulator, a 16-bit data register, an 11-bit address register and an 11-bit program counter. Each field is decoded one-hot on its own, so one cycle can combine up to three transfers. Every transfer in a cycle reads the register values held at the start of that cycle.

A 2048-word by 16-bit memory sits outside the block on a single read/write port. The address always comes from the address register and the write data always comes from the data register. The memory answers a read combinationally in the same cycle, and the data register captures that answer at the clock edge that ends the cycle. The block also drives the status lines used by an external sequencer: the indirect flag, the accumulator sign, an accumulator-is-zero flag, and the four opcode bits of the data register.

Top module: `uop_datapath`

## Requirements
- R1: While rst_ni is low, AC, DR, AR and PC are all zero, zero_flag_o is 1, and mem_we_o and mem_re_o are both 0.
- R2: Field f1_i encodings: 000 no operation; 001 AC<=AC+DR; 010 AC<=0; 011 AC<=AC+1; 100 AC<=DR; 101 AR<=DR[10:0]; 110 AR<=PC; 111 memory write of DR at address AR.
- R3: Field f2_i encodings: 000 no operation; 001 AC<=AC-DR; 010 AC<=AC|DR; 011 AC<=AC&DR; 100 DR<=memory at AR; 101 DR<=AC; 110 DR<=DR+1; 111 DR[10:0]<=PC with DR[15:11] kept.
- R4: Field f3_i encodings: 000 no operation; 001 AC<=AC^DR; 010 AC<=~AC; 011 AC shifted left one bit; 100 AC shifted right one bit; 101 PC<=PC+1; 110 PC<=AR; 111 leaves every register and the memory unchanged.
- R5: When more than one field writes AC in the same microinstruction, the f1_i operation takes effect over f2_i, and f2_i takes effect over f3_i.
- R6: Every transfer in a cycle uses the register values from the start of that cycle. For example, f1_i=100 with f2_i=101 swaps AC and DR.
- R7: mem_we_o is 1 exactly when f1_i=111, and mem_re_o is 1 exactly when f2_i=100. mem_addr_o equals AR and mem_wdata_o equals DR during the cycle. On a read, DR takes the value of mem_rdata_i at the edge that ends the cycle.
- R8: ind_flag_o is DR[15], sign_flag_o is AC[15], zero_flag_o is 1 exactly when AC is zero, and opcode_o is DR[14:11]. All of these follow the current register values.
- R9: Shifts are logical and fill with zero. AC and DR arithmetic wraps modulo 2^16, and the PC increment wraps modulo 2^11.
- R10: AR changes only when f1_i is 101 or 110. PC changes only when f3_i is 101 or 110.
- R11: A microinstruction with all three fields at 000 leaves AC, DR, AR and PC unchanged and raises no memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| f1_i | input | 3 | First microoperation field |
| f2_i | input | 3 | Second microoperation field |
| f3_i | input | 3 | Third microoperation field |
| mem_addr_o | output | 11 | Memory address, equal to AR |
| mem_wdata_o | output | 16 | Memory write data, equal to DR |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 16 | Memory read data, valid in the same cycle |
| ac_o | output | 16 | Accumulator |
| dr_o | output | 16 | Data register |
| ar_o | output | 11 | Address register |
| pc_o | output | 11 | Program counter |
| ind_flag_o | output | 1 | DR bit 15 |
| sign_flag_o | output | 1 | AC bit 15 |
| zero_flag_o | output | 1 | AC equals zero |
| opcode_o | output | 4 | DR bits 14..11 |

## Verification
The cases that are hardest to reach from the ports are same-cycle interactions that need particular register contents first. Examples are an AC/DR swap with two distinct values, a memory write combined with a DR increment followed by a read-back at the same AR, and logical shifts of a word whose top and bottom bits are both set. To reach them, the stimulus first loads a known pattern into the bench memory. It then steers PC and AR to chosen addresses with increment and copy microinstructions, pulls the data into DR and AC, and only then issues the combined microinstruction. After these directed cases, several thousand random microinstructions exercise every overlap of fields. A behavioural model in the bench checks the results on every clock.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int FW = 3;

  typedef enum logic [FW-1:0] {
    F1_NOP, F1_ADD_DR, F1_CLEAR_AC, F1_INC_AC,
    F1_LOAD_AC, F1_AR_FROM_DR, F1_AR_FROM_PC, F1_MEM_WR
  } f1_e;

  typedef enum logic [FW-1:0] {
    F2_NOP, F2_SUB_DR, F2_OR_DR, F2_AND_DR,
    F2_MEM_RD, F2_DR_FROM_AC, F2_INC_DR, F2_DR_FROM_PC
  } f2_e;

  typedef enum logic [FW-1:0] {
    F3_NOP, F3_XOR_DR, F3_NOT_AC, F3_SHL_AC,
    F3_SHR_AC, F3_INC_PC, F3_PC_FROM_AR, F3_SPARE
  } f3_e;
endpackage

// File: rtl/uop_field_dec.sv
module uop_field_dec #(
  parameter int FW = 3,
  localparam int NCODE = 1 << FW
) (
  input  logic [FW-1:0]    code_i,
  output logic [NCODE-1:0] sel_o
);
  for (genvar g = 0; g < NCODE; g++) begin : g_line
    assign sel_o[g] = (code_i == FW'(g));
  end
endmodule

// File: rtl/uop_ac_unit.sv
module uop_ac_unit
  import uop_pkg::*;
#(
  parameter int DW = 16,
  localparam int NCODE = 1 << FW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCODE-1:0] sel1_i,
  input  logic [NCODE-1:0] sel2_i,
  input  logic [NCODE-1:0] sel3_i,
  input  logic [DW-1:0]    dr_i,
  output logic [DW-1:0]    ac_o
);
  logic [DW-1:0] ac_q, ac_d;
  logic          f1_hit, f2_hit, f3_hit;

  assign f1_hit = sel1_i[F1_ADD_DR] | sel1_i[F1_CLEAR_AC] | sel1_i[F1_INC_AC] | sel1_i[F1_LOAD_AC];
  assign f2_hit = sel2_i[F2_SUB_DR] | sel2_i[F2_OR_DR] | sel2_i[F2_AND_DR];
  assign f3_hit = sel3_i[F3_XOR_DR] | sel3_i[F3_NOT_AC] | sel3_i[F3_SHL_AC] | sel3_i[F3_SHR_AC];

  // fixed priority F1 > F2 > F3 for AC writers
  always_comb begin
    ac_d = ac_q;
    if (f1_hit) begin
      if (sel1_i[F1_ADD_DR])        ac_d = ac_q + dr_i;
      else if (sel1_i[F1_CLEAR_AC]) ac_d = '0;
      else if (sel1_i[F1_INC_AC])   ac_d = ac_q + DW'(1);
      else                          ac_d = dr_i;
    end else if (f2_hit) begin
      if (sel2_i[F2_SUB_DR])        ac_d = ac_q - dr_i;
      else if (sel2_i[F2_OR_DR])    ac_d = ac_q | dr_i;
      else                          ac_d = ac_q & dr_i;
    end else if (f3_hit) begin
      if (sel3_i[F3_XOR_DR])        ac_d = ac_q ^ dr_i;
      else if (sel3_i[F3_NOT_AC])   ac_d = ~ac_q;
      else if (sel3_i[F3_SHL_AC])   ac_d = {ac_q[DW-2:0], 1'b0};
      else                          ac_d = {1'b0, ac_q[DW-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ac_q <= '0;
    else         ac_q <= ac_d;
  end

  assign ac_o = ac_q;

  // R4
  spare_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel3_i[F3_SPARE] && !f1_hit && !f2_hit) |=> $stable(ac_q));
  // R5
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel1_i[F1_CLEAR_AC] |=> (ac_q == '0));
endmodule

// File: rtl/uop_dr_unit.sv
module uop_dr_unit
  import uop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11,
  localparam int NCODE = 1 << FW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCODE-1:0] sel2_i,
  input  logic [DW-1:0]    ac_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [DW-1:0]    dr_o
);
  logic [DW-1:0] dr_q, dr_d;

  always_comb begin
    dr_d = dr_q;
    unique case (1'b1)
      sel2_i[F2_MEM_RD]:     dr_d = mem_rdata_i;
      sel2_i[F2_DR_FROM_AC]: dr_d = ac_i;
      sel2_i[F2_INC_DR]:     dr_d = dr_q + DW'(1);
      sel2_i[F2_DR_FROM_PC]: dr_d = {dr_q[DW-1:AW], pc_i};
      default:               dr_d = dr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dr_q <= '0;
    else         dr_q <= dr_d;
  end

  assign dr_o = dr_q;

  // R7
  rd_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel2_i[F2_MEM_RD] |=> (dr_q == $past(mem_rdata_i)));
endmodule

// File: rtl/uop_addr_unit.sv
module uop_addr_unit
  import uop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11,
  localparam int NCODE = 1 << FW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCODE-1:0] sel1_i,
  input  logic [NCODE-1:0] sel3_i,
  input  logic [DW-1:0]    dr_i,
  output logic [AW-1:0]    ar_o,
  output logic [AW-1:0]    pc_o
);
  logic [AW-1:0] ar_q, pc_q, ar_mux;
  logic          ar_ld;

  // AR source mux: PC or low DR bits
  assign ar_mux = sel1_i[F1_AR_FROM_PC] ? pc_q : dr_i[AW-1:0];
  assign ar_ld  = sel1_i[F1_AR_FROM_PC] | sel1_i[F1_AR_FROM_DR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q <= '0;
      pc_q <= '0;
    end else begin
      if (ar_ld) ar_q <= ar_mux;
      if (sel3_i[F3_INC_PC])          pc_q <= pc_q + AW'(1);
      else if (sel3_i[F3_PC_FROM_AR]) pc_q <= ar_q;
    end
  end

  assign ar_o = ar_q;
  assign pc_o = pc_q;

  // R10
  ar_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel1_i[F1_AR_FROM_PC] || sel1_i[F1_AR_FROM_DR]) |=> $stable(ar_q));
  // R10
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel3_i[F3_INC_PC] || sel3_i[F3_PC_FROM_AR]) |=> $stable(pc_q));
  // R9
  pc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel3_i[F3_INC_PC] |=> (pc_q == AW'($past(pc_q) + AW'(1))));
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 11,
  localparam int NCODE = 1 << FW,
  localparam int OPW = DW - AW - 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [FW-1:0]  f1_i,
  input  logic [FW-1:0]  f2_i,
  input  logic [FW-1:0]  f3_i,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           mem_we_o,
  output logic           mem_re_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [DW-1:0]  ac_o,
  output logic [DW-1:0]  dr_o,
  output logic [AW-1:0]  ar_o,
  output logic [AW-1:0]  pc_o,
  output logic           ind_flag_o,
  output logic           sign_flag_o,
  output logic           zero_flag_o,
  output logic [OPW-1:0] opcode_o
);
  logic [2:0][FW-1:0]    codes;
  logic [2:0][NCODE-1:0] sel;
  logic [DW-1:0]         ac, dr;
  logic [AW-1:0]         ar, pc;

  assign codes = {f3_i, f2_i, f1_i};

  for (genvar g = 0; g < 3; g++) begin : g_dec
    uop_field_dec #(.FW(FW)) u_dec (
      .code_i(codes[g]),
      .sel_o (sel[g])
    );
  end

  uop_ac_unit #(.DW(DW)) u_ac (
    .clk_i, .rst_ni,
    .sel1_i(sel[0]), .sel2_i(sel[1]), .sel3_i(sel[2]),
    .dr_i  (dr),
    .ac_o  (ac)
  );

  uop_dr_unit #(.DW(DW), .AW(AW)) u_dr (
    .clk_i, .rst_ni,
    .sel2_i     (sel[1]),
    .ac_i       (ac),
    .pc_i       (pc),
    .mem_rdata_i(mem_rdata_i),
    .dr_o       (dr)
  );

  uop_addr_unit #(.DW(DW), .AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .sel1_i(sel[0]), .sel3_i(sel[2]),
    .dr_i  (dr),
    .ar_o  (ar),
    .pc_o  (pc)
  );

  assign mem_addr_o  = ar;
  assign mem_wdata_o = dr;
  assign mem_we_o    = rst_ni & sel[0][F1_MEM_WR];
  assign mem_re_o    = rst_ni & sel[1][F2_MEM_RD];

  assign ac_o        = ac;
  assign dr_o        = dr;
  assign ar_o        = ar;
  assign pc_o        = pc;
  assign ind_flag_o  = dr[DW-1];
  assign sign_flag_o = ac[DW-1];
  assign zero_flag_o = (ac == '0);
  assign opcode_o    = dr[DW-2:AW];

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f1_i == '0 && f2_i == '0 && f3_i == '0)
      |=> ($stable(ac) && $stable(dr) && $stable(ar) && $stable(pc)));
  // R8
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel[0][F1_CLEAR_AC] |=> zero_flag_o);
endmodule

// File: tb/uop_datapath_tb_top.sv
module uop_datapath_tb_top;
  localparam int CLK_NS = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  f1_i = '0, f2_i = '0, f3_i = '0;
  logic [10:0] mem_addr_o, ar_o, pc_o;
  logic [15:0] mem_wdata_o, mem_rdata_i, ac_o, dr_o;
  logic        mem_we_o, mem_re_o, ind_flag_o, sign_flag_o, zero_flag_o;
  logic [3:0]  opcode_o;

  logic [15:0] mem [2048];
  logic [15:0] m_ac = '0, m_dr = '0;
  logic [10:0] m_ar = '0, m_pc = '0;
  int n_chk = 0, n_err = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;
  assign mem_rdata_i = mem[mem_addr_o];

  uop_datapath dut_i (
    .clk_i, .rst_ni, .f1_i, .f2_i, .f3_i,
    .mem_addr_o, .mem_wdata_o, .mem_we_o, .mem_re_o, .mem_rdata_i,
    .ac_o, .dr_o, .ar_o, .pc_o,
    .ind_flag_o, .sign_flag_o, .zero_flag_o, .opcode_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int a, input int b, input int c, input string tag);
    logic [15:0] n_ac, n_dr, rd;
    logic [10:0] n_ar, n_pc;
    f1_i = 3'(a); f2_i = 3'(b); f3_i = 3'(c);
    #1;
    chk({tag, " R7 strobes"}, {mem_we_o, mem_re_o, mem_addr_o, mem_wdata_o},
        {(a == 7), (b == 4), m_ar, m_dr});
    rd = mem[m_ar];
    n_ac = m_ac; n_dr = m_dr; n_ar = m_ar; n_pc = m_pc;
    if (a >= 1 && a <= 4) begin
      case (a)
        1: n_ac = m_ac + m_dr;
        2: n_ac = 16'h0;
        3: n_ac = m_ac + 16'h1;
        default: n_ac = m_dr;
      endcase
    end else if (b >= 1 && b <= 3) begin
      case (b)
        1: n_ac = m_ac - m_dr;
        2: n_ac = m_ac | m_dr;
        default: n_ac = m_ac & m_dr;
      endcase
    end else if (c >= 1 && c <= 4) begin
      case (c)
        1: n_ac = m_ac ^ m_dr;
        2: n_ac = ~m_ac;
        3: n_ac = m_ac << 1;
        default: n_ac = m_ac >> 1;
      endcase
    end
    case (b)
      4: n_dr = rd;
      5: n_dr = m_ac;
      6: n_dr = m_dr + 16'h1;
      7: n_dr = {m_dr[15:11], m_pc};
      default: ;
    endcase
    if (a == 5) n_ar = m_dr[10:0];
    if (a == 6) n_ar = m_pc;
    if (c == 5) n_pc = m_pc + 11'h1;
    if (c == 6) n_pc = m_ar;
    @(posedge clk_i);
    #1;
    if (a == 7) mem[m_ar] = m_dr;
    m_ac = n_ac; m_dr = n_dr; m_ar = n_ar; m_pc = n_pc;
    @(negedge clk_i);
    chk({tag, " regs"}, {ac_o, dr_o, ar_o, pc_o}, {m_ac, m_dr, m_ar, m_pc});
    chk({tag, " R8 flags"}, {ind_flag_o, sign_flag_o, zero_flag_o, opcode_o},
        {m_dr[15], m_ac[15], (m_ac == 16'h0), m_dr[14:11]});
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'(i * 40503 + 4660);
    mem[5] = 16'h8001;
    mem[0] = 16'h5A3C;
    @(negedge clk_i);
    @(negedge clk_i);
    // R1
    chk("R1 reset regs", {ac_o, dr_o, ar_o, pc_o}, 64'h0);
    chk("R1 reset flags", {zero_flag_o, mem_we_o, mem_re_o}, {1'b1, 1'b0, 1'b0});
    rst_ni = 1'b1;
    @(negedge clk_i);

    step(6, 0, 0, "R2 ar_from_pc");
    step(0, 4, 5, "R3 read+R10 inc_pc");
    step(4, 0, 0, "R2 load_ac");
    step(0, 6, 0, "R3 inc_dr");
    step(4, 5, 0, "R6 swap");
    step(2, 1, 1, "R5 clear_over_sub_xor");
    step(3, 3, 2, "R5 inc_over_and_not");
    step(0, 2, 3, "R5 or_over_shl");
    step(0, 0, 7, "R4 spare_code");
    step(0, 0, 0, "R11 idle");
    for (int k = 0; k < 4; k++) step(0, 0, 5, "R10 pc_step");
    step(6, 0, 0, "R10 ar_load");
    step(0, 4, 0, "R7 read_8001");
    step(4, 0, 0, "R2 ac_8001");
    step(0, 0, 3, "R9 shl_zero_fill");
    step(4, 0, 0, "R2 ac_reload");
    step(0, 0, 4, "R9 shr_zero_fill");
    step(2, 0, 0, "R8 zero_flag");
    step(0, 0, 2, "R9 not_all_ones");
    step(3, 0, 0, "R9 inc_wrap");
    step(0, 7, 0, "R3 dr_from_pc");
    step(7, 6, 0, "R7 write_old_dr");
    step(0, 4, 0, "R7 read_back");
    step(5, 0, 6, "R6 ar_from_dr_pc_from_old_ar");
    step(0, 0, 0, "R11 idle2");
    for (int k = 0; k < 2100; k++) step(0, 0, 5, "R9 pc_wrap");
    for (int k = 0; k < 4000; k++)
      step(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 7)), "R2/R3/R4 random");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_NS * 190000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule